// File: doc/BRIEF.md
# PCIe Receive Credit Return Controller

This block lives on the application side of a PCI Express receive path and owns the receive flow-control credits that the application hands back to the PCIe core. It tracks six credit classes: a header class and a data class for each of the three traffic categories (posted, non-posted, completion). After reset, each class raises its initialization indicator and waits for the core's acknowledge. It then advertises its configured receive-buffer capacity, or a single zero-count strobe that stands for unlimited credits, and drops the indicator to end the phase.

Once a class is initialized, the block accepts one drain event per cycle from the buffer logic. Each event carries a category, a header count and a data-credit count, and the amounts go into per-class pending accumulators. Credits are returned on per-category update strobes whose count fields have a fixed size. A header strobe releases at most 3 credits and a data strobe at most 15. A larger balance is therefore returned over consecutive strobes, while new events keep adding to the balance in the same cycles.

Top module: `rxcr_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge every init indicator, every update strobe and every count field is 0, and all pending balances are cleared.
- R2: On the first clock edge with `rst` low, every class raises its init indicator. The indicator stays high until that class's initial advertisement is complete.
- R3: A class issues no update strobe while its acknowledge input is low. Its first strobe comes on the edge after the acknowledge is seen high.
- R4: A finite class advertises its initial amount on consecutive strobes, one per cycle. Every strobe carries the per-strobe maximum (3 for header, 15 for data) except the last, which carries the remainder. The counts add up to the initial amount. A finite class with an initial amount of 0 advertises 1.
- R5: The init indicator of a class falls in the cycle that immediately follows its final initialization strobe.
- R6: A class configured as unlimited issues exactly one strobe during initialization, with a count of 0. It issues no strobe afterwards, whatever drain events arrive.
- R7: Category encoding on `ev_cat_i` and on the strobe bit order is 0 = posted, 1 = non-posted, 2 = completion. Category k uses strobe bit k, header count bits [2k+1:2k] and data count bits [4k+3:4k]. An event with category 3 is ignored.
- R8: A drain event that reaches an initialized, idle class appears as a strobe two clock edges after it is presented.
- R9: While a class's pending balance exceeds the per-strobe maximum, that class strobes the maximum on every cycle until the remainder is released.
- R10: After initialization, the credits a finite class returns add up exactly to the credits it was given by drain events. This includes events that arrive while that class is strobing.
- R11: After initialization, no strobe carries a count of 0.
- R12: Drain events that arrive while a class's init indicator is high are discarded for that class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid_i | input | 1 | Drain event valid |
| ev_cat_i | input | 2 | Drain event category |
| ev_hdr_i | input | HDR_EV_W (2) | Header credits freed by the event |
| ev_dat_i | input | DAT_EV_W (8) | Data credits freed by the event |
| hdr_ack_i | input | 3 | Header init acknowledge per category |
| dat_ack_i | input | 3 | Data init acknowledge per category |
| hdr_init_o | output | 3 | Header init indicator per category |
| hdr_upd_o | output | 3 | Header update strobe per category |
| hdr_cnt_o | output | 6 | Header credits released, 2 bits per category |
| dat_init_o | output | 3 | Data init indicator per category |
| dat_upd_o | output | 3 | Data update strobe per category |
| dat_cnt_o | output | 12 | Data credits released, 4 bits per category |

## Verification
The bench gives the posted class an initial amount of 7 header and 40 data credits, so that initialization needs three strobes with a partial last one on both the 3 and the 15 limits. The non-posted class gets 2 header and 15 data credits, which covers a single partial strobe and a single exactly-full strobe. The completion class is unlimited for both headers and data, which exercises the zero-count advertisement and the rule that such a class never strobes again. Event data counts of up to 40 push the finite balances above the per-strobe maximum while new events keep arriving, so the split-and-accumulate path is exercised under load.

// File: rtl/rxcr_pkg.sv
package rxcr_pkg;

    localparam int unsigned NUM_CAT   = 3;
    localparam int unsigned HDR_MAX   = 3;
    localparam int unsigned DAT_MAX   = 15;
    localparam int unsigned HDR_CNT_W = 2;
    localparam int unsigned DAT_CNT_W = 4;

    typedef enum logic [1:0] {
        CAT_POSTED    = 2'd0,
        CAT_NONPOSTED = 2'd1,
        CAT_COMPL     = 2'd2,
        CAT_RSVD      = 2'd3
    } rxcr_cat_e;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAIT = 3'd1,
        ST_SEND = 3'd2,
        ST_LAST = 3'd3,
        ST_RUN  = 3'd4
    } rxcr_state_e;

    function automatic bit cat_selects(rxcr_cat_e cat, int unsigned idx);
        return (cat != CAT_RSVD) && (int'(cat) == int'(idx));
    endfunction

    function automatic int unsigned init_amount(int unsigned req, bit unlimited);
        if (unlimited) return 0;
        return (req == 0) ? 1 : req;
    endfunction

endpackage

// File: rtl/rxcr_event_split.sv
module rxcr_event_split
    import rxcr_pkg::*;
#(
    parameter int unsigned HW = 2,
    parameter int unsigned DW = 8
) (
    input  logic                          valid_i,
    input  logic [1:0]                    cat_i,
    input  logic [HW-1:0]                 hdr_i,
    input  logic [DW-1:0]                 dat_i,
    output logic [NUM_CAT-1:0][HW-1:0]    hdr_add_o,
    output logic [NUM_CAT-1:0][DW-1:0]    dat_add_o
);

    rxcr_cat_e cat;
    assign cat = rxcr_cat_e'(cat_i);

    always_comb begin
        for (int k = 0; k < NUM_CAT; k++) begin
            if (valid_i && cat_selects(cat, k)) begin
                hdr_add_o[k] = hdr_i;
                dat_add_o[k] = dat_i;
            end else begin
                hdr_add_o[k] = '0;
                dat_add_o[k] = '0;
            end
        end
    end

endmodule

// File: rtl/rxcr_class_engine.sv
module rxcr_class_engine
    import rxcr_pkg::*;
#(
    parameter int unsigned MAX_REL   = 3,
    parameter int unsigned CNT_W     = 2,
    parameter int unsigned ADD_W     = 2,
    parameter int unsigned ACC_W     = 12,
    parameter int unsigned INIT_CRED = 8,
    parameter bit          UNLIMITED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_i,
    input  logic [ADD_W-1:0]  add_i,
    output logic              init_o,
    output logic              upd_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam int unsigned INIT_EFF = init_amount(INIT_CRED, UNLIMITED);
    localparam logic [ACC_W-1:0] INIT_V = ACC_W'(INIT_EFF);
    localparam logic [ACC_W-1:0] MAX_V  = ACC_W'(MAX_REL);

    rxcr_state_e      state_q;
    logic [ACC_W-1:0] pend_q;
    logic             upd_q;
    logic [CNT_W-1:0] cnt_q;

    logic [ACC_W-1:0] rel;
    logic [ACC_W-1:0] rem;
    logic [ACC_W:0]   run_next;

    // Release at most the per-strobe maximum; the rest stays pending.
    assign rel      = (pend_q > MAX_V) ? MAX_V : pend_q;
    assign rem      = pend_q - rel;
    assign run_next = {1'b0, rem} + (ACC_W+1)'(add_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            pend_q  <= '0;
            upd_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_q <= ST_WAIT;
                    pend_q  <= INIT_V;
                    upd_q   <= 1'b0;
                    cnt_q   <= '0;
                end
                ST_WAIT: begin
                    if (ack_i) begin
                        upd_q <= 1'b1;
                        if (UNLIMITED) begin
                            cnt_q   <= '0;
                            state_q <= ST_LAST;
                        end else begin
                            cnt_q   <= rel[CNT_W-1:0];
                            pend_q  <= rem;
                            state_q <= (rem == '0) ? ST_LAST : ST_SEND;
                        end
                    end else begin
                        upd_q <= 1'b0;
                        cnt_q <= '0;
                    end
                end
                ST_SEND: begin
                    upd_q   <= 1'b1;
                    cnt_q   <= rel[CNT_W-1:0];
                    pend_q  <= rem;
                    state_q <= (rem == '0) ? ST_LAST : ST_SEND;
                end
                ST_LAST: begin
                    upd_q   <= 1'b0;
                    cnt_q   <= '0;
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (UNLIMITED) begin
                        upd_q <= 1'b0;
                        cnt_q <= '0;
                    end else begin
                        upd_q  <= (pend_q != '0);
                        cnt_q  <= rel[CNT_W-1:0];
                        pend_q <= run_next[ACC_W-1:0];
                    end
                end
                default: begin
                    state_q <= ST_OFF;
                    upd_q   <= 1'b0;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign init_o = (state_q == ST_WAIT) || (state_q == ST_SEND) || (state_q == ST_LAST);
    assign upd_o  = upd_q;
    assign cnt_o  = cnt_q;

    // R1: reset silences the class
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!init_o && !upd_o && cnt_o == '0));

    // R3: no strobe while waiting without acknowledge
    p_ack_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !ack_i) |=> !upd_o);

    // R5: init drops right after the last init strobe
    p_init_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(init_o) |-> $past(upd_o));

    // R10: pending balance never wraps
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !UNLIMITED) |-> !run_next[ACC_W]);

    generate
        if (UNLIMITED) begin : g_unl
            // R6: unlimited class is silent after init
            p_unl_quiet_r6: assert property (@(posedge clk) disable iff (rst)
                !init_o |-> !upd_o);
        end else begin : g_fin
            // R11: no empty strobe after init
            p_run_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
                (!init_o && upd_o) |-> (cnt_o != '0));
            // R9: a large balance is released at the maximum
            p_full_first_r9: assert property (@(posedge clk) disable iff (rst)
                (state_q == ST_RUN && pend_q > MAX_V) |=>
                    (upd_o && cnt_o == CNT_W'(MAX_REL)));
        end
    endgenerate

endmodule

// File: rtl/rxcr_ctrl.sv
module rxcr_ctrl
    import rxcr_pkg::*;
#(
    parameter int unsigned HDR_EV_W     = 2,
    parameter int unsigned DAT_EV_W     = 8,
    parameter int unsigned HDR_ACC_W    = 10,
    parameter int unsigned DAT_ACC_W    = 14,
    parameter int unsigned P_HDR_INIT   = 16,
    parameter int unsigned NP_HDR_INIT  = 8,
    parameter int unsigned CPL_HDR_INIT = 32,
    parameter int unsigned P_DAT_INIT   = 64,
    parameter int unsigned NP_DAT_INIT  = 16,
    parameter int unsigned CPL_DAT_INIT = 128,
    parameter logic [2:0]  HDR_UNL      = 3'b000,
    parameter logic [2:0]  DAT_UNL      = 3'b000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_valid_i,
    input  logic [1:0]           ev_cat_i,
    input  logic [HDR_EV_W-1:0]  ev_hdr_i,
    input  logic [DAT_EV_W-1:0]  ev_dat_i,
    input  logic [2:0]           hdr_ack_i,
    input  logic [2:0]           dat_ack_i,
    output logic [2:0]           hdr_init_o,
    output logic [2:0]           hdr_upd_o,
    output logic [5:0]           hdr_cnt_o,
    output logic [2:0]           dat_init_o,
    output logic [2:0]           dat_upd_o,
    output logic [11:0]          dat_cnt_o
);

    localparam int unsigned HDR_INIT_A [NUM_CAT] = '{P_HDR_INIT, NP_HDR_INIT, CPL_HDR_INIT};
    localparam int unsigned DAT_INIT_A [NUM_CAT] = '{P_DAT_INIT, NP_DAT_INIT, CPL_DAT_INIT};

    logic [NUM_CAT-1:0][HDR_EV_W-1:0] hdr_add;
    logic [NUM_CAT-1:0][DAT_EV_W-1:0] dat_add;

    rxcr_event_split #(
        .HW (HDR_EV_W),
        .DW (DAT_EV_W)
    ) u_split (
        .valid_i   (ev_valid_i),
        .cat_i     (ev_cat_i),
        .hdr_i     (ev_hdr_i),
        .dat_i     (ev_dat_i),
        .hdr_add_o (hdr_add),
        .dat_add_o (dat_add)
    );

    generate
        for (genvar g = 0; g < NUM_CAT; g++) begin : g_cat
            rxcr_class_engine #(
                .MAX_REL   (HDR_MAX),
                .CNT_W     (HDR_CNT_W),
                .ADD_W     (HDR_EV_W),
                .ACC_W     (HDR_ACC_W),
                .INIT_CRED (HDR_INIT_A[g]),
                .UNLIMITED (HDR_UNL[g])
            ) u_hdr (
                .clk    (clk),
                .rst    (rst),
                .ack_i  (hdr_ack_i[g]),
                .add_i  (hdr_add[g]),
                .init_o (hdr_init_o[g]),
                .upd_o  (hdr_upd_o[g]),
                .cnt_o  (hdr_cnt_o[HDR_CNT_W*g +: HDR_CNT_W])
            );

            rxcr_class_engine #(
                .MAX_REL   (DAT_MAX),
                .CNT_W     (DAT_CNT_W),
                .ADD_W     (DAT_EV_W),
                .ACC_W     (DAT_ACC_W),
                .INIT_CRED (DAT_INIT_A[g]),
                .UNLIMITED (DAT_UNL[g])
            ) u_dat (
                .clk    (clk),
                .rst    (rst),
                .ack_i  (dat_ack_i[g]),
                .add_i  (dat_add[g]),
                .init_o (dat_init_o[g]),
                .upd_o  (dat_upd_o[g]),
                .cnt_o  (dat_cnt_o[DAT_CNT_W*g +: DAT_CNT_W])
            );
        end
    endgenerate

endmodule

// File: tb/rxcr_ctrl_bench.sv
module rxcr_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_cat = 2'd0;
    logic [1:0]  ev_hdr = 2'd0;
    logic [7:0]  ev_dat = 8'd0;
    logic [2:0]  hdr_ack = 3'b000;
    logic [2:0]  dat_ack = 3'b000;
    logic [2:0]  hdr_init, hdr_upd, dat_init, dat_upd;
    logic [5:0]  hdr_cnt;
    logic [11:0] dat_cnt;

    always #4 clk = ~clk;

    rxcr_ctrl #(
        .P_HDR_INIT   (7),
        .NP_HDR_INIT  (2),
        .CPL_HDR_INIT (5),
        .P_DAT_INIT   (40),
        .NP_DAT_INIT  (15),
        .CPL_DAT_INIT (9),
        .HDR_UNL      (3'b100),
        .DAT_UNL      (3'b100)
    ) u_rxcr_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev_valid_i (ev_valid),
        .ev_cat_i   (ev_cat),
        .ev_hdr_i   (ev_hdr),
        .ev_dat_i   (ev_dat),
        .hdr_ack_i  (hdr_ack),
        .dat_ack_i  (dat_ack),
        .hdr_init_o (hdr_init),
        .hdr_upd_o  (hdr_upd),
        .hdr_cnt_o  (hdr_cnt),
        .dat_init_o (dat_init),
        .dat_upd_o  (dat_upd),
        .dat_cnt_o  (dat_cnt)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;
    bit run_phase = 1'b0;

    // classes 0..2 header posted/non-posted/completion, 3..5 data
    int EXP_INIT [6] = '{7, 2, 0, 40, 15, 0};
    bit UNL      [6] = '{0, 0, 1, 0, 0, 1};
    int MAXR     [6] = '{3, 3, 3, 15, 15, 15};

    int init_sum [6];
    int init_n   [6];
    int run_sum  [6];
    int exp_run  [6];
    bit prev_init[6];
    bit prev_upd [6];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit b_init(int c);
        return (c < 3) ? hdr_init[c] : dat_init[c-3];
    endfunction
    function automatic bit b_upd(int c);
        return (c < 3) ? hdr_upd[c] : dat_upd[c-3];
    endfunction
    function automatic int b_cnt(int c);
        return (c < 3) ? int'(hdr_cnt[2*c +: 2]) : int'(dat_cnt[4*(c-3) +: 4]);
    endfunction
    function automatic bit b_ack(int c);
        return (c < 3) ? hdr_ack[c] : dat_ack[c-3];
    endfunction
    function automatic int exp_strobes(int c);
        return UNL[c] ? 1 : (EXP_INIT[c] + MAXR[c] - 1) / MAXR[c];
    endfunction
    function automatic int next_init_cnt(int c);
        int left;
        if (UNL[c]) return 0;
        left = EXP_INIT[c] - init_sum[c];
        return (left > MAXR[c]) ? MAXR[c] : left;
    endfunction

    // Observer of all six classes
    always @(negedge clk) begin
        if (mon_en) begin
            for (int c = 0; c < 6; c++) begin
                bit i, u;
                int n;
                i = b_init(c);
                u = b_upd(c);
                n = b_cnt(c);
                if (u && !b_ack(c)) chk(1'b0, "R3 strobe without ack", 1, 0);
                if (i && u) begin
                    chk(n == next_init_cnt(c), "R4 init strobe count", n, next_init_cnt(c));
                    if (UNL[c]) chk(init_n[c] == 0, "R6 single unlimited strobe", init_n[c], 0);
                    init_sum[c] += n;
                    init_n[c]++;
                end
                if (i && !u && init_n[c] > 0) chk(1'b0, "R4 gap in init strobes", 0, 1);
                if (prev_init[c] && !i) begin
                    chk(prev_upd[c], "R5 init fall after last strobe", int'(prev_upd[c]), 1);
                    chk(init_n[c] == exp_strobes(c), "R4 init strobe number", init_n[c], exp_strobes(c));
                end
                if (!i && u) begin
                    chk(n != 0 && n <= MAXR[c], "R11 run strobe count range", n, MAXR[c]);
                    if (UNL[c]) chk(1'b0, "R6 unlimited class strobed after init", n, 0);
                    run_sum[c] += n;
                end
                prev_init[c] = i;
                prev_upd[c]  = u;
            end
        end
    end

    task automatic put_event(int cat, int h, int d);
        ev_valid = 1'b1;
        ev_cat   = 2'(cat);
        ev_hdr   = 2'(h);
        ev_dat   = 8'(d);
        if (run_phase && cat < 3) begin
            if (!UNL[cat])   exp_run[cat]   += h;
            if (!UNL[cat+3]) exp_run[cat+3] += d;
        end
    endtask

    task automatic idle_event();
        ev_valid = 1'b0;
        ev_hdr   = 2'd0;
        ev_dat   = 8'd0;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int c = 0; c < 6; c++) begin
            init_sum[c] = 0; init_n[c] = 0; run_sum[c] = 0; exp_run[c] = 0;
            prev_init[c] = 0; prev_upd[c] = 0;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(hdr_init == 3'b000 && dat_init == 3'b000, "R1 init low in reset", int'({hdr_init, dat_init}), 0);
        chk(hdr_upd == 3'b000 && dat_upd == 3'b000, "R1 strobes low in reset", int'({hdr_upd, dat_upd}), 0);
        chk(hdr_cnt == 6'd0 && dat_cnt == 12'd0, "R1 counts zero in reset", int'({hdr_cnt, dat_cnt}), 0);

        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        // R2: init rises on first edge after reset
        chk(hdr_init == 3'b111 && dat_init == 3'b111, "R2 init high after reset", int'({hdr_init, dat_init}), 63);

        // R12: event during init is discarded (not added to expectation)
        put_event(0, 3, 30);
        @(negedge clk);
        idle_event();
        repeat (3) @(negedge clk);
        // R3: no strobes without ack
        chk(hdr_upd == 3'b000 && dat_upd == 3'b000, "R3 quiet before ack", int'({hdr_upd, dat_upd}), 0);
        chk(hdr_init == 3'b111 && dat_init == 3'b111, "R2 init held before ack", int'({hdr_init, dat_init}), 63);

        hdr_ack = 3'b111;
        dat_ack = 3'b111;
        repeat (8) @(negedge clk);
        chk(hdr_init == 3'b000 && dat_init == 3'b000, "R2 init done", int'({hdr_init, dat_init}), 0);
        for (int c = 0; c < 6; c++)
            chk(init_sum[c] == (UNL[c] ? 0 : EXP_INIT[c]), "R4 init total", init_sum[c], EXP_INIT[c]);
        run_phase = 1'b1;

        // R8 / R7: single event latency and field positions
        put_event(0, 1, 4);
        @(negedge clk);
        idle_event();
        chk(hdr_upd == 3'b000 && dat_upd == 3'b000, "R8 no strobe after one edge", int'({hdr_upd, dat_upd}), 0);
        @(negedge clk);
        chk(hdr_upd == 3'b001 && hdr_cnt == 6'h01, "R8 R7 posted header strobe", int'({hdr_upd, hdr_cnt}), 'h41);
        chk(dat_upd == 3'b001 && dat_cnt == 12'h004, "R8 R7 posted data strobe", int'({dat_upd, dat_cnt}), 'h1004);
        @(negedge clk);

        // R9: large balance split 15,15,10 on non-posted data
        put_event(1, 2, 40);
        @(negedge clk);
        idle_event();
        @(negedge clk);
        chk(dat_upd == 3'b010 && dat_cnt == 12'h0F0, "R9 R7 first full strobe", int'({dat_upd, dat_cnt}), 'h20F0);
        chk(hdr_upd == 3'b010 && hdr_cnt == 6'h08, "R7 non-posted header field", int'({hdr_upd, hdr_cnt}), 'h88);
        @(negedge clk);
        chk(dat_upd == 3'b010 && dat_cnt == 12'h0F0, "R9 second full strobe", int'({dat_upd, dat_cnt}), 'h20F0);
        @(negedge clk);
        chk(dat_upd == 3'b010 && dat_cnt == 12'h0A0, "R9 remainder strobe", int'({dat_upd, dat_cnt}), 'h20A0);
        @(negedge clk);
        chk(dat_upd == 3'b000, "R9 balance drained", int'(dat_upd), 0);

        // R7: reserved category ignored
        put_event(3, 3, 50);
        @(negedge clk);
        idle_event();
        for (int k = 0; k < 4; k++) begin
            chk(hdr_upd == 3'b000 && dat_upd == 3'b000, "R7 reserved category ignored", int'({hdr_upd, dat_upd}), 0);
            @(negedge clk);
        end

        // R6: unlimited completion class ignores events
        put_event(2, 3, 35);
        @(negedge clk);
        idle_event();
        repeat (3) @(negedge clk);
        chk(hdr_upd[2] == 1'b0 && dat_upd[2] == 1'b0, "R6 unlimited ignores events", int'({hdr_upd[2], dat_upd[2]}), 0);

        // R10: random load with events during ongoing strobes
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 2 == 0) put_event(int'($urandom % 4), int'($urandom % 4), int'($urandom % 41));
            else idle_event();
            @(negedge clk);
        end
        idle_event();
        repeat (150) @(negedge clk);
        for (int c = 0; c < 6; c++)
            chk(run_sum[c] == exp_run[c], "R10 returned equals consumed", run_sum[c], exp_run[c]);

        // R12 discard made the posted totals exclude the init-time event
        chk(run_sum[0] == exp_run[0], "R12 init-time event discarded", run_sum[0], exp_run[0]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule